// File: doc/BRIEF.md
# SPI Queue Memory with Status and Pointer Control

This block is the shared storage behind a queued SPI controller. It holds three segments in one 80-byte window: sixteen 16-bit receive words, sixteen 16-bit transmit words and sixteen 8-bit command bytes. A host bus reaches every segment with byte, word or long-word transfers. A queue engine on a second port fetches a transmit word and a command byte for the entry it is about to run. When that entry finishes, the engine writes the received word back.

Next to the memory sit two registers. The status word reports which queue entry completed last, plus two flags that only the engine can raise. The host can only clear them, and only with a read-then-write-zero sequence. The control word holds the queue end and restart pointers. Host writes to it are parked in a pending copy and take effect when the engine next restarts. Host reads and the pointer outputs always show the active copy.

Host reads return their data one cycle after the request. Received words are stored right-aligned, and every bit above the engine's reported bit count is forced to zero.

Top module: `spi_queue_mem`

## Requirements
- R1: Address map. Receive words are at offsets 0x00–0x1E, transmit words at 0x20–0x3E and command bytes at 0x40–0x4F. The control word is at 0x50 and the status word at 0x52. Within a word, the even byte address selects bits 15:8 and the odd one selects bits 7:0. Read data appears right-aligned on hostRdata one cycle after the request.
- R2: hostSize encodes the transfer size: 0 byte, 1 word, 2 long. A long access covers two consecutive words, or four consecutive command bytes. The lower address goes in bits 31:16, or bits 31:24 for command bytes.
- R3: The following requests raise hostErr one cycle later, return zero data and change no state: a word at an odd address, a long at an address that is not a multiple of 4, size code 3, a non-word access to 0x50/0x52, and any other address at or above 0x50.
- R4: An engine completion (engDone) writes engRxWord into receive word engDoneIdx. Bits at positions equal to or above engRxBits are stored as zero. A count of 16 or more keeps the whole word.
- R5: When engFetch is high, engTxWord and engCmdByte show the transmit word and the command byte at engFetchIdx one cycle later, and hold otherwise. The engine never changes the transmit segment.
- R6: The status word reads as follows: bits 3:0 give the index of the last completed entry; bit 8 is set when an entry completes whose index equals the active end pointer; bit 9 is set by an engHalt pulse. All bits are zero after reset.
- R7: A host write of 0 to a status flag clears it only if the host last read that flag as 1. Writing 1, or writing before such a read, has no effect. An engine set in the same cycle as a clear wins.
- R8: Control word bits 3:0 hold the end pointer and bits 11:8 the restart pointer, which reset to 15 and 0. Host writes land in a pending copy that is moved to the active copy on engRestart. Reads, queueEnd and queueStart show the active copy.
- R9: If the host reads a receive word in the same cycle as the engine writes it, the host gets the old value. If both write the same word in the same cycle, the engine's value is kept.
- R10: After reset, every memory location reads as zero, and hostRdata and hostErr are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostSel | input | 1 | Host request this cycle |
| hostWe | input | 1 | Host request is a write |
| hostSize | input | 2 | Transfer size code |
| hostAddr | input | 7 | Byte offset in the window |
| hostWdata | input | 32 | Host write data, right-aligned |
| hostRdata | output | 32 | Host read data, one cycle after the request |
| hostErr | output | 1 | Rejected request, one cycle after it |
| engFetch | input | 1 | Engine fetch strobe |
| engFetchIdx | input | 4 | Entry to fetch |
| engTxWord | output | 16 | Fetched transmit word |
| engCmdByte | output | 8 | Fetched command byte |
| engDone | input | 1 | Entry completion strobe |
| engDoneIdx | input | 4 | Completed entry |
| engRxWord | input | 16 | Received data |
| engRxBits | input | 5 | Valid bits in engRxWord |
| engHalt | input | 1 | Engine halt event |
| engRestart | input | 1 | Engine restart, loads pending pointers |
| queueEnd | output | 4 | Active end pointer |
| queueStart | output | 4 | Active restart pointer |

## Verification
Two pairs of actions can land in the same cycle.

The first pair is a host access to a receive word and an engine completion on that same word. The bench issues the host read, or the host write, in the same cycle as engDone. It then checks that the read returned the earlier contents and that a later read shows the engine's value.

The second pair is a host flag clear and an engine set of the same flag. The bench first arms the flag by reading it, then writes zero to the status word while pulsing engHalt. It checks that the flag still reads as set.

// File: rtl/spi_queue_mem_pkg.sv
package spi_queue_mem_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_BAD  = 2'd3
  } accSize_e;

  typedef enum logic [2:0] {
    SEG_NONE,
    SEG_RX,
    SEG_TX,
    SEG_CMD,
    SEG_CTL,
    SEG_STA
  } seg_e;

  // strobes handed from control to datapath
  typedef struct packed {
    seg_e     seg;
    logic     wr;
    logic     rd;
    accSize_e size;
    logic     err;
  } hostStrobe_t;

  localparam int END_FLAG_BIT  = 8;
  localparam int HALT_FLAG_BIT = 9;
  localparam int RESTART_LSB   = 8;

endpackage

// File: rtl/spi_queue_mem_ctrl.sv
module spi_queue_mem_ctrl
  import spi_queue_mem_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 7,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWe,
  input  logic [1:0]        hostSize,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [IDX_W-1:0]  wrEnd,
  input  logic [IDX_W-1:0]  wrStart,
  input  logic              wrKeepEnd,
  input  logic              wrKeepHalt,
  input  logic              engDone,
  input  logic [IDX_W-1:0]  engDoneIdx,
  input  logic              engHalt,
  input  logic              engRestart,
  output hostStrobe_t       strobe,
  output logic [IDX_W:0]    segOff,
  output logic [15:0]       regRdData,
  output logic [IDX_W-1:0]  queueEnd,
  output logic [IDX_W-1:0]  queueStart
);

  localparam logic [ADDR_W-1:0] TX_BASE  = ADDR_W'(2 * ENTRIES);
  localparam logic [ADDR_W-1:0] CMD_BASE = ADDR_W'(4 * ENTRIES);
  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(5 * ENTRIES);
  localparam logic [ADDR_W-1:0] STA_ADDR = ADDR_W'(5 * ENTRIES + 2);

  seg_e seg;
  logic misAlign, bad;
  logic [IDX_W-1:0] actEnd, actStart, pendEnd, pendStart, lastIdx;
  logic flagEnd, flagHalt, armEnd, armHalt;
  logic ctlWrite, staWrite, staRead;
  logic setEnd, setHalt, clrEnd, clrHalt;

  always_comb begin
    seg = SEG_NONE;
    if (hostAddr < TX_BASE)        seg = SEG_RX;
    else if (hostAddr < CMD_BASE)  seg = SEG_TX;
    else if (hostAddr < CTL_ADDR)  seg = SEG_CMD;
    else if (hostAddr == CTL_ADDR) seg = SEG_CTL;
    else if (hostAddr == STA_ADDR) seg = SEG_STA;
    case (hostSize)
      2'd0:    misAlign = 1'b0;
      2'd1:    misAlign = hostAddr[0];
      2'd2:    misAlign = |hostAddr[1:0];
      default: misAlign = 1'b1;
    endcase
    bad = (seg == SEG_NONE) || misAlign ||
          (((seg == SEG_CTL) || (seg == SEG_STA)) && (hostSize != 2'd1));
  end

  assign strobe = '{seg:  seg,
                    wr:   hostSel && hostWe && !bad,
                    rd:   hostSel && !hostWe && !bad,
                    size: accSize_e'(hostSize),
                    err:  hostSel && bad};

  // segment sizes are powers of two, so the low address bits are the offset
  assign segOff = hostAddr[IDX_W:0];

  assign ctlWrite = strobe.wr && (seg == SEG_CTL);
  assign staWrite = strobe.wr && (seg == SEG_STA);
  assign staRead  = strobe.rd && (seg == SEG_STA);
  assign setEnd   = engDone && (engDoneIdx == actEnd);
  assign setHalt  = engHalt;
  assign clrEnd   = staWrite && armEnd && !wrKeepEnd;
  assign clrHalt  = staWrite && armHalt && !wrKeepHalt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actEnd    <= IDX_W'(ENTRIES - 1);
      pendEnd   <= IDX_W'(ENTRIES - 1);
      actStart  <= '0;
      pendStart <= '0;
      lastIdx   <= '0;
      flagEnd   <= 1'b0;
      flagHalt  <= 1'b0;
      armEnd    <= 1'b0;
      armHalt   <= 1'b0;
    end else begin
      if (ctlWrite) begin
        pendEnd   <= wrEnd;
        pendStart <= wrStart;
      end
      if (engRestart) begin
        actEnd   <= pendEnd;
        actStart <= pendStart;
      end
      if (engDone) lastIdx <= engDoneIdx;
      flagEnd  <= setEnd  || (flagEnd  && !clrEnd);
      flagHalt <= setHalt || (flagHalt && !clrHalt);
      armEnd   <= (armEnd  && !clrEnd)  || (staRead && flagEnd);
      armHalt  <= (armHalt && !clrHalt) || (staRead && flagHalt);
    end
  end

  always_comb begin
    regRdData = '0;
    if (seg == SEG_CTL) begin
      regRdData[IDX_W-1:0]          = actEnd;
      regRdData[RESTART_LSB+:IDX_W] = actStart;
    end else begin
      regRdData[IDX_W-1:0]     = lastIdx;
      regRdData[END_FLAG_BIT]  = flagEnd;
      regRdData[HALT_FLAG_BIT] = flagHalt;
    end
  end

  assign queueEnd   = actEnd;
  assign queueStart = actStart;

  AST_HALT_SET_WINS: assert property (@(posedge clk) disable iff (!rstN) engHalt |=> flagHalt); // R7
  AST_FLAG_FROM_ENGINE: assert property (@(posedge clk) disable iff (!rstN) $rose(flagHalt) |-> $past(engHalt)); // R6
  AST_END_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN) (engDone && engDoneIdx == actEnd) |=> flagEnd); // R6
  AST_ACTIVE_BUFFERED: assert property (@(posedge clk) disable iff (!rstN) !engRestart |=> ($stable(actEnd) && $stable(actStart))); // R8

endmodule

// File: rtl/spi_queue_mem_dp.sv
module spi_queue_mem_dp
  import spi_queue_mem_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int WORD_W  = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int BYTE_W = WORD_W / 2,
  localparam int LONG_W = 2 * WORD_W,
  localparam int BITS_W = $clog2(WORD_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  hostStrobe_t       strobe,
  input  logic [IDX_W:0]    segOff,
  input  logic [LONG_W-1:0] hostWdata,
  input  logic [15:0]       regRdData,
  output logic [LONG_W-1:0] hostRdata,
  output logic              hostErr,
  input  logic              engFetch,
  input  logic [IDX_W-1:0]  engFetchIdx,
  output logic [WORD_W-1:0] engTxWord,
  output logic [BYTE_W-1:0] engCmdByte,
  input  logic              engDone,
  input  logic [IDX_W-1:0]  engDoneIdx,
  input  logic [WORD_W-1:0] engRxWord,
  input  logic [BITS_W-1:0] engRxBits
);

  logic [WORD_W-1:0] rxMem  [ENTRIES];
  logic [WORD_W-1:0] txMem  [ENTRIES];
  logic [BYTE_W-1:0] cmdMem [ENTRIES];

  logic [IDX_W-1:0] wIdx, wIdx1, bIdx, bIdx1, bIdx2, bIdx3;
  logic lane;
  logic [WORD_W-1:0] wFirst, wSecond, rxMasked;
  logic [LONG_W-1:0] rdNext;

  assign wIdx  = segOff[IDX_W:1];
  assign wIdx1 = wIdx + IDX_W'(1);
  assign bIdx  = segOff[IDX_W-1:0];
  assign bIdx1 = bIdx + IDX_W'(1);
  assign bIdx2 = bIdx + IDX_W'(2);
  assign bIdx3 = bIdx + IDX_W'(3);
  assign lane  = segOff[0];

  always_comb begin
    for (int i = 0; i < WORD_W; i++)
      rxMasked[i] = (BITS_W'(i) < engRxBits) && engRxWord[i];
  end

  always_comb begin
    wFirst  = (strobe.seg == SEG_RX) ? rxMem[wIdx]  : txMem[wIdx];
    wSecond = (strobe.seg == SEG_RX) ? rxMem[wIdx1] : txMem[wIdx1];
    rdNext  = '0;
    case (strobe.seg)
      SEG_RX, SEG_TX:
        case (strobe.size)
          SZ_BYTE: rdNext = LONG_W'(lane ? wFirst[BYTE_W-1:0] : wFirst[WORD_W-1:BYTE_W]);
          SZ_WORD: rdNext = LONG_W'(wFirst);
          SZ_LONG: rdNext = {wFirst, wSecond};
          default: rdNext = '0;
        endcase
      SEG_CMD:
        case (strobe.size)
          SZ_BYTE: rdNext = LONG_W'(cmdMem[bIdx]);
          SZ_WORD: rdNext = LONG_W'({cmdMem[bIdx], cmdMem[bIdx1]});
          SZ_LONG: rdNext = {cmdMem[bIdx], cmdMem[bIdx1], cmdMem[bIdx2], cmdMem[bIdx3]};
          default: rdNext = '0;
        endcase
      SEG_CTL, SEG_STA: rdNext = LONG_W'(regRdData);
      default: rdNext = '0;
    endcase
  end

  function automatic logic [WORD_W-1:0] mergeWord(input logic [WORD_W-1:0] oldW,
                                                 input logic segHit,
                                                 input logic [IDX_W-1:0] e);
    logic [WORD_W-1:0] r;
    r = oldW;
    if (strobe.wr && segHit) begin
      case (strobe.size)
        SZ_BYTE: if (wIdx == e) begin
          if (lane) r[BYTE_W-1:0] = hostWdata[BYTE_W-1:0];
          else      r[WORD_W-1:BYTE_W] = hostWdata[BYTE_W-1:0];
        end
        SZ_WORD: if (wIdx == e) r = hostWdata[WORD_W-1:0];
        SZ_LONG: begin
          if (wIdx == e)       r = hostWdata[LONG_W-1:WORD_W];
          else if (wIdx1 == e) r = hostWdata[WORD_W-1:0];
        end
        default: ;
      endcase
    end
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] mergeByte(input logic [BYTE_W-1:0] oldB,
                                                 input logic [IDX_W-1:0] e);
    logic [BYTE_W-1:0] r;
    r = oldB;
    if (strobe.wr && strobe.seg == SEG_CMD) begin
      case (strobe.size)
        SZ_BYTE: if (bIdx == e) r = hostWdata[0+:BYTE_W];
        SZ_WORD: begin
          if (bIdx == e)       r = hostWdata[BYTE_W+:BYTE_W];
          else if (bIdx1 == e) r = hostWdata[0+:BYTE_W];
        end
        SZ_LONG: begin
          if (bIdx == e)       r = hostWdata[3*BYTE_W+:BYTE_W];
          else if (bIdx1 == e) r = hostWdata[2*BYTE_W+:BYTE_W];
          else if (bIdx2 == e) r = hostWdata[BYTE_W+:BYTE_W];
          else if (bIdx3 == e) r = hostWdata[0+:BYTE_W];
        end
        default: ;
      endcase
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) begin
        rxMem[e]  <= '0;
        txMem[e]  <= '0;
        cmdMem[e] <= '0;
      end
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        // engine completion overrides a host write to the same word
        rxMem[e]  <= (engDone && engDoneIdx == IDX_W'(e)) ? rxMasked
                   : mergeWord(rxMem[e], strobe.seg == SEG_RX, IDX_W'(e));
        txMem[e]  <= mergeWord(txMem[e], strobe.seg == SEG_TX, IDX_W'(e));
        cmdMem[e] <= mergeByte(cmdMem[e], IDX_W'(e));
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostRdata  <= '0;
      hostErr    <= 1'b0;
      engTxWord  <= '0;
      engCmdByte <= '0;
    end else begin
      hostRdata <= strobe.rd ? rdNext : '0;
      hostErr   <= strobe.err;
      if (engFetch) begin
        engTxWord  <= txMem[engFetchIdx];
        engCmdByte <= cmdMem[engFetchIdx];
      end
    end
  end

  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rstN) hostErr |-> (hostRdata == '0)); // R3
  AST_RX_ZERO_FILL: assert property (@(posedge clk) disable iff (!rstN) (engDone && engRxBits <= BITS_W'(BYTE_W)) |=> (rxMem[$past(engDoneIdx)][WORD_W-1:BYTE_W] == '0)); // R4
  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rstN) !engFetch |=> ($stable(engTxWord) && $stable(engCmdByte))); // R5

endmodule

// File: rtl/spi_queue_mem.sv
module spi_queue_mem
  import spi_queue_mem_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int WORD_W  = 16,
  parameter int ADDR_W  = 7,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int BYTE_W = WORD_W / 2,
  localparam int LONG_W = 2 * WORD_W,
  localparam int BITS_W = $clog2(WORD_W) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWe,
  input  logic [1:0]        hostSize,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [LONG_W-1:0] hostWdata,
  output logic [LONG_W-1:0] hostRdata,
  output logic              hostErr,
  input  logic              engFetch,
  input  logic [IDX_W-1:0]  engFetchIdx,
  output logic [WORD_W-1:0] engTxWord,
  output logic [BYTE_W-1:0] engCmdByte,
  input  logic              engDone,
  input  logic [IDX_W-1:0]  engDoneIdx,
  input  logic [WORD_W-1:0] engRxWord,
  input  logic [BITS_W-1:0] engRxBits,
  input  logic              engHalt,
  input  logic              engRestart,
  output logic [IDX_W-1:0]  queueEnd,
  output logic [IDX_W-1:0]  queueStart
);

  hostStrobe_t      strobe;
  logic [IDX_W:0]   segOff;
  logic [15:0]      regRdData;

  spi_queue_mem_ctrl #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .hostSel    (hostSel),
    .hostWe     (hostWe),
    .hostSize   (hostSize),
    .hostAddr   (hostAddr),
    .wrEnd      (hostWdata[IDX_W-1:0]),
    .wrStart    (hostWdata[RESTART_LSB+:IDX_W]),
    .wrKeepEnd  (hostWdata[END_FLAG_BIT]),
    .wrKeepHalt (hostWdata[HALT_FLAG_BIT]),
    .engDone    (engDone),
    .engDoneIdx (engDoneIdx),
    .engHalt    (engHalt),
    .engRestart (engRestart),
    .strobe     (strobe),
    .segOff     (segOff),
    .regRdData  (regRdData),
    .queueEnd   (queueEnd),
    .queueStart (queueStart)
  );

  spi_queue_mem_dp #(.ENTRIES(ENTRIES), .WORD_W(WORD_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .segOff      (segOff),
    .hostWdata   (hostWdata),
    .regRdData   (regRdData),
    .hostRdata   (hostRdata),
    .hostErr     (hostErr),
    .engFetch    (engFetch),
    .engFetchIdx (engFetchIdx),
    .engTxWord   (engTxWord),
    .engCmdByte  (engCmdByte),
    .engDone     (engDone),
    .engDoneIdx  (engDoneIdx),
    .engRxWord   (engRxWord),
    .engRxBits   (engRxBits)
  );

endmodule

// File: tb/spi_queue_mem_tb_top.sv
module spi_queue_mem_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostSel = 1'b0, hostWe = 1'b0;
  logic [1:0]  hostSize = 2'd0;
  logic [6:0]  hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        hostErr;
  logic        engFetch = 1'b0;
  logic [3:0]  engFetchIdx = '0;
  logic [15:0] engTxWord;
  logic [7:0]  engCmdByte;
  logic        engDone = 1'b0;
  logic [3:0]  engDoneIdx = '0;
  logic [15:0] engRxWord = '0;
  logic [4:0]  engRxBits = '0;
  logic        engHalt = 1'b0, engRestart = 1'b0;
  logic [3:0]  queueEnd, queueStart;

  int total = 0;
  int bad = 0;

  typedef struct {
    logic [31:0] data;
    logic        err;
    string       tag;
  } exp_t;
  exp_t sb[$];
  logic accIssued = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_queue_mem dut_i (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWe(hostWe), .hostSize(hostSize),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata), .hostErr(hostErr),
    .engFetch(engFetch), .engFetchIdx(engFetchIdx), .engTxWord(engTxWord),
    .engCmdByte(engCmdByte), .engDone(engDone), .engDoneIdx(engDoneIdx),
    .engRxWord(engRxWord), .engRxBits(engRxBits), .engHalt(engHalt),
    .engRestart(engRestart), .queueEnd(queueEnd), .queueStart(queueStart)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: every host request leaves one expected item
  always @(posedge clk) accIssued <= hostSel;
  always @(negedge clk) begin
    if (rstN && accIssued) begin
      if (sb.size() == 0) check("scoreboard empty", 32'd1, 32'd0);
      else begin
        exp_t it;
        it = sb.pop_front();
        check({it.tag, " data"}, hostRdata, it.data);
        check({it.tag, " err"}, {31'd0, hostErr}, {31'd0, it.err});
      end
    end
  end

  task automatic hostAcc(input bit we, input logic [1:0] sz, input logic [6:0] a,
                         input logic [31:0] wd, input logic [31:0] ed, input bit ee,
                         input string tag);
    exp_t it;
    hostSel = 1'b1; hostWe = we; hostSize = sz; hostAddr = a; hostWdata = wd;
    it.data = ed; it.err = ee; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic engComplete(input logic [3:0] idx, input logic [15:0] d, input logic [4:0] bits);
    engDone = 1'b1; engDoneIdx = idx; engRxWord = d; engRxBits = bits;
  endtask

  task automatic tick();
    @(negedge clk);
    hostSel = 1'b0; hostWe = 1'b0;
    engDone = 1'b0; engFetch = 1'b0; engHalt = 1'b0; engRestart = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sz, input logic [6:0] a, input logic [31:0] d, input string tag);
    hostAcc(1'b1, sz, a, d, 32'd0, 1'b0, tag);
    tick();
  endtask

  task automatic rd(input logic [1:0] sz, input logic [6:0] a, input logic [31:0] e, input string tag);
    hostAcc(1'b0, sz, a, 32'd0, e, 1'b0, tag);
    tick();
  endtask

  task automatic fetchChk(input logic [3:0] idx, input logic [15:0] tx, input logic [7:0] cmd);
    engFetch = 1'b1; engFetchIdx = idx;
    tick();
    check("R5 fetch tx", {16'd0, engTxWord}, {16'd0, tx});
    check("R5 fetch cmd", {24'd0, engCmdByte}, {24'd0, cmd});
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 reset rdata", hostRdata, 32'd0);
    check("R10 reset err", {31'd0, hostErr}, 32'd0);
    check("R8 reset end", {28'd0, queueEnd}, 32'd15);
    check("R8 reset start", {28'd0, queueStart}, 32'd0);
    rd(2'd1, 7'h52, 32'h0, "R6 reset status");
    rd(2'd2, 7'h00, 32'h0, "R10 reset rx long");

    // R1 / R2 transmit segment, all sizes
    wr(2'd1, 7'h20, 32'h0000A1B2, "R1 tx word wr");
    wr(2'd0, 7'h23, 32'h0000005C, "R2 tx byte wr");
    wr(2'd2, 7'h24, 32'h11223344, "R2 tx long wr");
    rd(2'd1, 7'h20, 32'h0000A1B2, "R1 tx word");
    rd(2'd0, 7'h20, 32'h000000A1, "R1 high lane");
    rd(2'd0, 7'h21, 32'h000000B2, "R1 low lane");
    rd(2'd1, 7'h22, 32'h0000005C, "R2 byte merged");
    rd(2'd2, 7'h20, 32'hA1B2005C, "R2 long read");
    rd(2'd2, 7'h24, 32'h11223344, "R2 long write");

    // command bytes
    wr(2'd2, 7'h40, 32'hDEADBEEF, "R2 cmd long wr");
    wr(2'd1, 7'h4E, 32'h00001234, "R2 cmd word wr");
    rd(2'd0, 7'h42, 32'h000000BE, "R1 cmd byte");
    rd(2'd0, 7'h4F, 32'h00000034, "R1 cmd odd byte");
    rd(2'd2, 7'h4C, 32'h00001234, "R10 cmd long");

    // R3 rejected requests
    hostAcc(1'b0, 2'd1, 7'h21, 32'd0, 32'd0, 1'b1, "R3 odd word"); tick();
    hostAcc(1'b0, 2'd2, 7'h22, 32'd0, 32'd0, 1'b1, "R3 unaligned long"); tick();
    hostAcc(1'b1, 2'd1, 7'h23, 32'hFFFF, 32'd0, 1'b1, "R3 bad write"); tick();
    hostAcc(1'b0, 2'd3, 7'h20, 32'd0, 32'd0, 1'b1, "R3 size code"); tick();
    hostAcc(1'b0, 2'd1, 7'h54, 32'd0, 32'd0, 1'b1, "R3 past window"); tick();
    hostAcc(1'b0, 2'd0, 7'h50, 32'd0, 32'd0, 1'b1, "R3 byte on reg"); tick();
    rd(2'd0, 7'h23, 32'h0000005C, "R3 write ignored");

    // R5 engine fetch
    fetchChk(4'd1, 16'h005C, 8'hAD);
    fetchChk(4'd0, 16'hA1B2, 8'hDE);

    // R4 zero fill
    engComplete(4'd3, 16'hFFFF, 5'd12); tick();
    rd(2'd1, 7'h06, 32'h00000FFF, "R4 12 bits");
    engComplete(4'd4, 16'hABCD, 5'd16); tick();
    rd(2'd1, 7'h08, 32'h0000ABCD, "R4 full word");
    rd(2'd1, 7'h52, 32'h00000004, "R6 last index");

    // R7 clear rules
    engHalt = 1'b1; tick();
    wr(2'd1, 7'h52, 32'h0, "R7 unarmed clear");
    rd(2'd1, 7'h52, 32'h00000204, "R7 not cleared");
    wr(2'd1, 7'h52, 32'h00000200, "R7 write one");
    rd(2'd1, 7'h52, 32'h00000204, "R7 one ignored");
    wr(2'd1, 7'h52, 32'h0, "R7 armed clear");
    rd(2'd1, 7'h52, 32'h00000004, "R7 cleared");
    engHalt = 1'b1; tick();
    rd(2'd1, 7'h52, 32'h00000204, "R7 arm again");
    hostAcc(1'b1, 2'd1, 7'h52, 32'h0, 32'd0, 1'b0, "R7 clear vs set");
    engHalt = 1'b1; tick();
    rd(2'd1, 7'h52, 32'h00000204, "R7 set wins");

    // R8 buffered pointers
    wr(2'd1, 7'h50, 32'h00000305, "R8 ctl wr");
    rd(2'd1, 7'h50, 32'h0000000F, "R8 read active");
    check("R8 end before restart", {28'd0, queueEnd}, 32'd15);
    engRestart = 1'b1; tick();
    check("R8 end after restart", {28'd0, queueEnd}, 32'd5);
    check("R8 start after restart", {28'd0, queueStart}, 32'd3);
    rd(2'd1, 7'h50, 32'h00000305, "R8 read loaded");

    // R6 end flag
    engComplete(4'd5, 16'h1357, 5'd16); tick();
    rd(2'd1, 7'h52, 32'h00000305, "R6 end flag");
    rd(2'd1, 7'h0A, 32'h00001357, "R4 rx5");

    // R9 collisions on receive word 7
    wr(2'd1, 7'h0E, 32'h00001111, "R9 seed");
    hostAcc(1'b0, 2'd1, 7'h0E, 32'd0, 32'h00001111, 1'b0, "R9 read old");
    engComplete(4'd7, 16'h2222, 5'd16); tick();
    rd(2'd1, 7'h0E, 32'h00002222, "R9 engine stored");
    hostAcc(1'b1, 2'd1, 7'h0E, 32'h00003333, 32'd0, 1'b0, "R9 dual write");
    engComplete(4'd7, 16'h4444, 5'd16); tick();
    rd(2'd1, 7'h0E, 32'h00004444, "R9 engine wins");

    rd(2'd1, 7'h20, 32'h0000A1B2, "R5 tx untouched");
    tick(); tick();
    check("scoreboard drained", sb.size(), 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule